// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns characters handed over by a host into asynchronous serial frames on one output line. Each frame opens with a low start bit, carries the data bits least-significant first, optionally adds a parity bit, and closes with a high stop period. The character length, parity mode, stop length and bit rate come from an 8-bit configuration word. Every bit lasts a whole number of ticks of a transmit tick input that is synchronous to the system clock.

A one-character holding register sits in front of the shift register. The host polls the ready flag, writes a byte, and the block starts the frame as soon as the line is free, transmission is enabled and the far end reports clear-to-send. A break control overrides the line and pulls it low. The empty flag tells the host that no character is left anywhere in the transmitter.

Top module: `serTx`

## Requirements
- R1: A frame is a start bit at 0, then the data bits least-significant bit first, then an optional parity bit, then the stop period at 1. Each bit lasts exactly one bit period.
- R2: Configuration bits [1:0] select the character length: 00 means 5 bits, 01 means 6, 10 means 7 and 11 means 8. Data bits above the selected length are not sent.
- R3: Configuration bit 4 set to 1 adds a parity bit. Bit 5 set to 1 selects even parity and 0 selects odd. Parity covers only the data bits that are sent.
- R4: Configuration bits [7:6] set the stop period. 10 gives 1.5 bit periods and 11 gives 2. Code 01, and the unused code 00, give 1. When the bit period is one tick, the 1.5 setting lasts 2 ticks.
- R5: Configuration bits [3:2] set the bit period: 01 means 1 tick, 10 means 16 ticks and 11 means 64 ticks. With code 00 no new frame starts.
- R6: The idle line is high. `txEmpty` is 1 exactly when both the holding register and the shift register are empty.
- R7: A write clears `txReady` on the next cycle. `txReady` returns to 1 when the held character moves into the shift register. A write while `txReady` is 0 replaces the held character.
- R8: A frame starts only while `txEnable` and `clearToSend` are both 1.
- R9: While `sendBreak` is 1, `txLine` is 0.
- R10: When a character is held as a frame's stop period ends, the next start bit follows the last stop tick with no idle tick in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | One-cycle transmit tick; bit timing counts these |
| txCfg | input | 8 | Frame format configuration word |
| txData | input | 8 | Character to send |
| txWrite | input | 1 | Write strobe for `txData` |
| txEnable | input | 1 | Transmit enable |
| clearToSend | input | 1 | Far end ready to accept data (active high) |
| sendBreak | input | 1 | Forces the line low |
| txLine | output | 1 | Serial output line |
| txReady | output | 1 | Holding register can take a character |
| txEmpty | output | 1 | Nothing is held and nothing is being shifted |

## Verification
The assertions assume that `txCfg` stays constant while a frame is in flight and that `sendBreak` is used only while the line would otherwise be idle. The stimulus therefore changes the configuration only after `txEmpty` has been high for several cycles, and it asserts break only on an empty transmitter. The frame monitor assumes the host writes only when `txReady` is high. The single replacement test is the one exception, and it is run with transmission disabled so that the held character cannot move.

// File: rtl/serTxPkg.sv
package serTxPkg;

  // Configuration word layout, bit 7 down to bit 0
  typedef struct packed {
    logic [1:0] stopCode;
    logic       parityEven;
    logic       parityOn;
    logic [1:0] divCode;
    logic [1:0] lenCode;
  } txCfg_t;

  typedef enum logic [1:0] {
    LINE_IDLE,
    LINE_START,
    LINE_DATA,
    LINE_PARITY
  } lineSel_e;

  typedef struct packed {
    logic     loadShift;
    logic     shiftNext;
    lineSel_e lineSel;
  } txStrobe_t;

endpackage

// File: rtl/serTxCtrl.sv
module serTxCtrl
  import serTxPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MID_DIV = 16,
  parameter int MAX_DIV = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  txCfg_t     cfg,
  input  logic       txEnable,
  input  logic       clearToSend,
  input  logic       holdFull,
  output txStrobe_t  strobe,
  output logic       shiftIdle
);

  localparam int CNT_W  = $clog2(2 * MAX_DIV + 1);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int MIN_LEN = DATA_W - 3;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP} txState_e;

  txState_e   state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] bitTicks;
  logic [CNT_W-1:0] stopTicks;
  logic [CNT_W-1:0] phaseLimit;
  logic [BIT_W:0]   charLen;
  logic phaseEnd;
  logic frameEnd;
  logic canGo;
  logic loadNow;
  logic lastBit;

  always_comb begin
    case (cfg.divCode)
      2'b10:   bitTicks = CNT_W'(MID_DIV);
      2'b11:   bitTicks = CNT_W'(MAX_DIV);
      default: bitTicks = CNT_W'(1);
    endcase
  end

  always_comb begin
    case (cfg.stopCode)
      2'b10:   stopTicks = (bitTicks == CNT_W'(1)) ? CNT_W'(2)
                                                   : bitTicks + (bitTicks >> 1);
      2'b11:   stopTicks = bitTicks << 1;
      default: stopTicks = bitTicks;
    endcase
  end

  assign charLen    = (BIT_W+1)'(MIN_LEN) + (BIT_W+1)'(cfg.lenCode);
  assign phaseLimit = (state == ST_STOP) ? stopTicks : bitTicks;
  assign phaseEnd   = baudTick && (state != ST_IDLE) && (tickCnt == phaseLimit - CNT_W'(1));
  assign frameEnd   = phaseEnd && (state == ST_STOP);
  assign canGo      = txEnable && clearToSend && (cfg.divCode != 2'b00);
  assign loadNow    = holdFull && canGo && ((state == ST_IDLE) || frameEnd);
  assign lastBit    = ({1'b0, bitCnt} == charLen - (BIT_W+1)'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (loadNow) begin
      state   <= ST_START;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (phaseEnd) begin
      tickCnt <= '0;
      case (state)
        ST_START: state <= ST_DATA;
        ST_DATA: begin
          if (lastBit) state <= cfg.parityOn ? ST_PARITY : ST_STOP;
          else         bitCnt <= bitCnt + BIT_W'(1);
        end
        ST_PARITY: state <= ST_STOP;
        default:   state <= ST_IDLE;
      endcase
    end else if (baudTick && state != ST_IDLE) begin
      tickCnt <= tickCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobe.loadShift = loadNow;
    strobe.shiftNext = phaseEnd && (state == ST_DATA);
    case (state)
      ST_START:  strobe.lineSel = LINE_START;
      ST_DATA:   strobe.lineSel = LINE_DATA;
      ST_PARITY: strobe.lineSel = LINE_PARITY;
      default:   strobe.lineSel = LINE_IDLE;
    endcase
  end

  assign shiftIdle = (state == ST_IDLE);

endmodule

// File: rtl/serTxData.sv
module serTxData
  import serTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  input  txCfg_t            cfg,
  input  txStrobe_t         strobe,
  output logic              holdFull,
  output logic              lineOut
);

  localparam int MIN_LEN = DATA_W - 3;

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] lenMask;
  logic              parityReg;
  logic              parityCalc;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign lenMask[i] = (i < MIN_LEN + int'(cfg.lenCode));
  end

  assign parityCalc = cfg.parityEven ? (^(holdReg & lenMask)) : ~(^(holdReg & lenMask));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else begin
      if (txWrite) holdReg <= txData;
      holdFull <= txWrite || (holdFull && !strobe.loadShift);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityReg <= 1'b0;
    end else if (strobe.loadShift) begin
      shiftReg  <= holdReg;
      parityReg <= parityCalc;
    end else if (strobe.shiftNext) begin
      shiftReg  <= {1'b0, shiftReg[DATA_W-1:1]};
    end
  end

  always_comb begin
    case (strobe.lineSel)
      LINE_START:  lineOut = 1'b0;
      LINE_DATA:   lineOut = shiftReg[0];
      LINE_PARITY: lineOut = parityReg;
      default:     lineOut = 1'b1;
    endcase
  end

endmodule

// File: rtl/serTx.sv
module serTx
  import serTxPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MID_DIV = 16,
  parameter int MAX_DIV = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic [7:0]        txCfg,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  input  logic              txEnable,
  input  logic              clearToSend,
  input  logic              sendBreak,
  output logic              txLine,
  output logic              txReady,
  output logic              txEmpty
);

  txCfg_t    cfg;
  txStrobe_t strobe;
  logic      holdFull;
  logic      shiftIdle;
  logic      frameLine;

  assign cfg = txCfg_t'(txCfg);

  serTxCtrl #(.DATA_W(DATA_W), .MID_DIV(MID_DIV), .MAX_DIV(MAX_DIV)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .baudTick    (baudTick),
    .cfg         (cfg),
    .txEnable    (txEnable),
    .clearToSend (clearToSend),
    .holdFull    (holdFull),
    .strobe      (strobe),
    .shiftIdle   (shiftIdle)
  );

  serTxData #(.DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .txData   (txData),
    .txWrite  (txWrite),
    .cfg      (cfg),
    .strobe   (strobe),
    .holdFull (holdFull),
    .lineOut  (frameLine)
  );

  assign txLine  = frameLine && !sendBreak;
  assign txReady = !holdFull;
  assign txEmpty = !holdFull && shiftIdle;

endmodule

// File: rtl/serTxChk.sv
module serTxChk (
  input logic clk,
  input logic rstN,
  input logic txWrite,
  input logic txEnable,
  input logic clearToSend,
  input logic sendBreak,
  input logic txLine,
  input logic txReady,
  input logic txEmpty
);

  // R9
  break_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    sendBreak |-> !txLine);

  // R6
  empty_implies_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> txReady);

  // R6
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !sendBreak) |-> txLine);

  // R7
  write_clears_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    txWrite |=> !txReady);

  // R8
  start_needs_go_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReady) |-> $past(txEnable && clearToSend));

endmodule

bind serTx serTxChk u_serTxChk (
  .clk         (clk),
  .rstN        (rstN),
  .txWrite     (txWrite),
  .txEnable    (txEnable),
  .clearToSend (clearToSend),
  .sendBreak   (sendBreak),
  .txLine      (txLine),
  .txReady     (txReady),
  .txEmpty     (txEmpty)
);

// File: tb/test_serTx.sv
`timescale 1ns/1ps
module test_serTx;

  typedef struct {
    logic [7:0] data;
    int         len;
    bit         parOn;
    bit         parVal;
  } expItem_t;

  logic clk = 0;
  logic rstN = 0;
  logic baudTick = 0;
  logic [7:0] txCfg = 8'h4F;
  logic [7:0] txData = 0;
  logic txWrite = 0, txEnable = 0, clearToSend = 0, sendBreak = 0;
  logic txLine, txReady, txEmpty;

  int checks = 0;
  int errors = 0;
  bit monOn = 1;
  bit finished = 0;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  serTx i_serTx (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txCfg(txCfg), .txData(txData),
    .txWrite(txWrite), .txEnable(txEnable), .clearToSend(clearToSend),
    .sendBreak(sendBreak), .txLine(txLine), .txReady(txReady), .txEmpty(txEmpty)
  );

  // tick on every second cycle
  initial forever begin
    @(negedge clk);
    baudTick = ~baudTick;
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int bitPeriod(input logic [7:0] c);
    case (c[3:2])
      2'b10: return 16;
      2'b11: return 64;
      default: return 1;
    endcase
  endfunction

  function automatic int stopPeriod(input logic [7:0] c);
    int d = bitPeriod(c);
    case (c[7:6])
      2'b10: return (d == 1) ? 2 : d + d / 2;
      2'b11: return 2 * d;
      default: return d;
    endcase
  endfunction

  function automatic int frameTicks(input logic [7:0] c);
    return bitPeriod(c) * (1 + 5 + int'(c[1:0]) + int'(c[4])) + stopPeriod(c);
  endfunction

  function automatic expItem_t mkExp(input logic [7:0] d);
    expItem_t e;
    logic [7:0] m;
    e.len = 5 + int'(txCfg[1:0]);
    m = 8'hFF >> (8 - e.len);
    e.data = d & m;
    e.parOn = txCfg[4];
    e.parVal = txCfg[5] ? ^(d & m) : ~(^(d & m));
    return e;
  endfunction

  task automatic rawWrite(input logic [7:0] d, input bit push);
    txData = d;
    txWrite = 1;
    if (push) expQ.push_back(mkExp(d));
    @(negedge clk);
    txWrite = 0;
    chk("R7 ready cleared by write", txReady == 0, txReady, 0);
  endtask

  task automatic sendChar(input logic [7:0] d);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    rawWrite(d, 1);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!txEmpty) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic getSample(output logic s);
    @(negedge clk);
    while (!baudTick) @(negedge clk);
    s = txLine;
  endtask

  task automatic measureTicks(output int n);
    n = 0;
    @(negedge clk);
    while (txLine !== 1'b0) @(negedge clk);
    while (!txEmpty) begin
      if (baudTick) n++;
      @(negedge clk);
    end
  endtask

  // monitor: rebuilds each frame from tick samples and scores it
  initial begin
    logic s, v;
    logic [7:0] got;
    logic gotPar;
    int d;
    bit shapeOk, stopOk;
    expItem_t e;
    @(posedge rstN);
    forever begin
      getSample(s);
      if (monOn && s == 1'b0) begin
        d = bitPeriod(txCfg);
        shapeOk = 1;
        got = 0;
        gotPar = 0;
        for (int k = 1; k < d; k++) begin getSample(s); if (s != 0) shapeOk = 0; end
        for (int i = 0; i < 5 + int'(txCfg[1:0]); i++) begin
          getSample(v);
          for (int k = 1; k < d; k++) begin getSample(s); if (s != v) shapeOk = 0; end
          got[i] = v;
        end
        if (txCfg[4]) begin
          getSample(gotPar);
          for (int k = 1; k < d; k++) begin getSample(s); if (s != gotPar) shapeOk = 0; end
        end
        stopOk = 1;
        for (int k = 0; k < stopPeriod(txCfg); k++) begin getSample(s); if (s != 1) stopOk = 0; end
        if (expQ.size() == 0) begin
          chk("R1 unexpected frame", 0, got, 0);
        end else begin
          e = expQ.pop_front();
          chk("R1 R2 data bits", got == e.data, got, e.data);
          chk("R5 bit period shape", shapeOk, shapeOk, 1);
          chk("R4 stop period high", stopOk, stopOk, 1);
          if (e.parOn) chk("R3 parity bit", gotPar == e.parVal, gotPar, e.parVal);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R6 reset state
    chk("R6 idle line high", txLine == 1, txLine, 1);
    chk("R6 empty after reset", txEmpty == 1, txEmpty, 1);
    chk("R7 ready after reset", txReady == 1, txReady, 1);

    txEnable = 1; clearToSend = 1;
    // 8 bits, no parity, 1 stop, 1 tick per bit
    txCfg = 8'b01_0_0_01_11;
    sendChar(8'hA5); sendChar(8'h3C); sendChar(8'hFF); sendChar(8'h00);
    waitIdle();
    chk("R6 empty after frames", txEmpty == 1 && txLine == 1, txEmpty, 1);

    // 7 bits, even parity, 2 stop, 1 tick per bit
    txCfg = 8'b11_1_1_01_10;
    sendChar(8'hDA); sendChar(8'h81);
    waitIdle();

    // 5 bits, odd parity, 1.5 stop, 16 ticks per bit; R4 timing
    txCfg = 8'b10_0_1_10_00;
    sendChar(8'h13);
    waitIdle();
    fork
      measureTicks(n);
      sendChar(8'h1F);
    join
    chk("R4 1.5 stop at 16 ticks frame length", n == frameTicks(txCfg), n, frameTicks(txCfg));
    waitIdle();

    // 6 bits, even parity, 1 stop, 64 ticks per bit
    txCfg = 8'b01_1_1_11_01;
    sendChar(8'h2D);
    waitIdle();

    // R4: 1.5 stop with 1 tick per bit lasts 2 ticks
    txCfg = 8'b10_0_0_01_11;
    fork
      measureTicks(n);
      sendChar(8'h96);
    join
    chk("R4 1.5 stop at 1 tick frame length", n == 11, n, 11);
    waitIdle();

    // R10 back-to-back frames
    txCfg = 8'b01_0_0_01_11;
    fork
      measureTicks(n);
      begin sendChar(8'h11); sendChar(8'h22); end
    join
    chk("R10 back-to-back total ticks", n == 20, n, 20);
    waitIdle();

    // R8 enable and clear-to-send gate the start
    txEnable = 0;
    sendChar(8'h77);
    repeat (100) @(negedge clk);
    chk("R8 no start without enable", txLine == 1 && txEmpty == 0, txLine, 1);
    txEnable = 1; clearToSend = 0;
    repeat (100) @(negedge clk);
    chk("R8 no start without clear-to-send", txLine == 1 && txReady == 0, txReady, 0);
    clearToSend = 1;
    waitIdle();

    // R5 divisor code 00 blocks the start
    txCfg = 8'b01_0_0_00_11;
    sendChar(8'h5E);
    repeat (100) @(negedge clk);
    chk("R5 no start with divisor 00", txLine == 1 && txReady == 0, txReady, 0);
    txCfg = 8'b01_0_0_01_11;
    waitIdle();

    // R7 write while full replaces the held character
    txEnable = 0;
    rawWrite(8'h11, 0);
    rawWrite(8'hC3, 1);
    txEnable = 1;
    waitIdle();

    // R9 break forces the line low
    monOn = 0;
    sendBreak = 1;
    @(negedge clk);
    chk("R9 break low", txLine == 0, txLine, 0);
    repeat (20) @(negedge clk);
    chk("R9 break held low", txLine == 0, txLine, 0);
    sendBreak = 0;
    @(negedge clk);
    chk("R6 line high after break", txLine == 1, txLine, 1);
    repeat (4) @(negedge clk);
    monOn = 1;

    chk("R1 all frames seen", expQ.size() == 0, expQ.size(), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule